// File: doc/BRIEF.md
# DRAM ECC Error Capture Unit

This block sits beside the SECDED checker of a DRAM controller and keeps a record of the errors that checker reports. On every read the checker may raise a single-bit (corrected) or a double-bit (uncorrectable) pulse. It also presents the failing access's chip select, bank, row and column, the 64-bit read word, and the received and recomputed check bytes. The unit counts both kinds of event separately. It keeps a snapshot of the latest error it was allowed to capture, and it raises per-kind flags that can drive an interrupt line through a mask.

Software reaches every register through a flat 32-bit port. A write takes effect at the next clock edge, and reads are combinational. A programmable threshold decides how many single-bit errors must build up before one is captured and flagged. Double-bit errors are always captured. A global enable turns all of this on and off.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Register offsets are as follows. CONFIG is 0x00, CONTROL is 0x04, FLAGS is 0x08, IRQMASK is 0x0C, SBE count is 0x10, DBE count is 0x14, error location is 0x18, row/recomputed check is 0x1C, received check is 0x20, data high word is 0x24 and data low word is 0x28. CONFIG bit 18 is the ECC enable. While it is 0, error pulses change no counter, flag or capture register.
- R3: Each enabled single-bit pulse adds one to the SBE counter, and each enabled double-bit pulse adds one to the DBE counter. When both pulse in the same cycle, both counters advance.
- R4: Writing 0 to a counter clears it. Writing a nonzero value to a counter leaves it unchanged.
- R5: A counter stops at its all-ones value and does not wrap.
- R6: CONTROL bits 23:16 hold the single-bit threshold. A single-bit error is captured, and sets FLAGS bit 0, only when the threshold is nonzero and the SBE count that includes this error is at least the threshold. Below the threshold the error is counted only.
- R7: Every enabled double-bit error is captured and sets FLAGS bit 1. Each capture replaces all earlier captured values.
- R8: The error location register holds the error type in bit 0 (1 = double-bit), the chip select in bits 2:1, the column in bits 22:8 and the bank in bits 25:23. All other bits are zero.
- R9: The row/recomputed check register holds the recomputed check byte in bits 7:0 and the row in bits 23:8. The received check register holds the received byte in bits 7:0. The data registers hold read data bits 63:32 and 31:0.
- R10: A FLAGS write clears each flag whose written bit (bits 1:0) is 0 and keeps each flag whose written bit is 1.
- R11: `irq` is high exactly when some FLAGS bit is set together with its IRQMASK bit (bits 1:0, same positions).
- R12: When single-bit and double-bit errors arrive in the same cycle, the double-bit error wins the capture, and the type bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| errSbe | input | 1 | Single-bit error pulse from the checker |
| errDbe | input | 1 | Double-bit error pulse from the checker |
| errCs | input | 2 | Chip select of the failing access |
| errBank | input | 3 | Bank of the failing access |
| errRow | input | 16 | Row of the failing access |
| errCol | input | 15 | Column of the failing access |
| errData | input | 64 | Read data word of the failing access |
| eccRecv | input | 8 | Check byte read from memory |
| eccCalc | input | 8 | Check byte recomputed from the data |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Masked OR of the error flags |

## Verification
The bound checker watches several rules on every cycle. A disabled unit never moves its counters or flags. A counter only falls on a software write and holds at all-ones. An enabled double-bit pulse always sets its flag. A simultaneous pair always records type 1. The threshold arithmetic, the exact field packing of the capture registers, the selective flag clearing and the mask-driven interrupt are shown only by the bench's scenarios. Those scenarios compare read-back values against numbers computed from the requirements.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam int THR_W  = 8;
  localparam int CS_W   = 2;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 16;
  localparam int COL_W  = 15;
  localparam int CHK_W  = 8;
  localparam int DATA_W = 64;

  localparam int EN_BIT  = 18;
  localparam int THR_LSB = 16;

  localparam logic [ADDR_W-1:0] OFS_CFG   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_FLAGS = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_SBEC  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DBEC  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_LOC   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CALC  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_RECV  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_DHI   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_DLO   = 8'h28;

  typedef struct packed {
    logic incSbe;
    logic incDbe;
    logic capture;
    logic capDbe;
    logic setSbe;
    logic setDbe;
    logic clrSbeCnt;
    logic clrDbeCnt;
    logic wrCfg;
    logic wrCtrl;
    logic wrFlags;
    logic wrMask;
  } strobe_t;
endpackage

// File: rtl/ecc_cap_satcnt.sv
module ecc_cap_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            q <= '0;
    else if (clr)         q <= '0;
    else if (inc && q != MAXV) q <= q + 1'b1;
  end
endmodule

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
  import ecc_cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 eccEn,
  input  logic [THR_W-1:0]     thr,
  input  logic [CNT_W-1:0]     sbeCnt,
  input  logic                 errSbe,
  input  logic                 errDbe,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWdata,
  output strobe_t              stb
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] sbeWithThis;
  logic [CMP_W-1:0] cntWide;
  logic [CMP_W-1:0] thrWide;
  logic             thrMet;
  logic             wrZero;
  logic             sbeLive;
  logic             dbeLive;

  always_comb begin
    sbeWithThis = (sbeCnt == CNT_MAX) ? sbeCnt : sbeCnt + 1'b1;
    cntWide     = CMP_W'(sbeWithThis);
    thrWide     = CMP_W'(thr);
    thrMet      = (thr != '0) && (cntWide >= thrWide);
    wrZero      = (regWdata == '0);
    sbeLive     = eccEn && errSbe;
    dbeLive     = eccEn && errDbe;

    stb           = '0;
    stb.incSbe    = sbeLive;
    stb.incDbe    = dbeLive;
    stb.setDbe    = dbeLive;
    stb.setSbe    = sbeLive && thrMet;
    stb.capDbe    = dbeLive;
    stb.capture   = dbeLive || (sbeLive && thrMet);
    stb.clrSbeCnt = regWr && regAddr == OFS_SBEC && wrZero;
    stb.clrDbeCnt = regWr && regAddr == OFS_DBEC && wrZero;
    stb.wrCfg     = regWr && regAddr == OFS_CFG;
    stb.wrCtrl    = regWr && regAddr == OFS_CTRL;
    stb.wrFlags   = regWr && regAddr == OFS_FLAGS;
    stb.wrMask    = regWr && regAddr == OFS_MASK;
  end
endmodule

// File: rtl/ecc_cap_dp.sv
module ecc_cap_dp
  import ecc_cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [CS_W-1:0]      errCs,
  input  logic [BANK_W-1:0]    errBank,
  input  logic [ROW_W-1:0]     errRow,
  input  logic [COL_W-1:0]     errCol,
  input  logic [DATA_W-1:0]    errData,
  input  logic [CHK_W-1:0]     eccRecv,
  input  logic [CHK_W-1:0]     eccCalc,
  input  logic                 wdEn,
  input  logic [THR_W-1:0]     wdThr,
  input  logic [1:0]           wdBits,
  input  logic [ADDR_W-1:0]    regAddr,
  output logic [REG_W-1:0]     regRdata,
  output logic                 irq,
  output logic                 eccEn,
  output logic [THR_W-1:0]     thr,
  output logic [CNT_W-1:0]     sbeCnt,
  output logic [CNT_W-1:0]     dbeCnt,
  output logic [1:0]           flags,
  output logic                 capType
);
  logic [1:0]          maskQ;
  logic [CS_W-1:0]     capCs;
  logic [BANK_W-1:0]   capBank;
  logic [ROW_W-1:0]    capRow;
  logic [COL_W-1:0]    capCol;
  logic [DATA_W-1:0]   capData;
  logic [CHK_W-1:0]    capRecv;
  logic [CHK_W-1:0]    capCalc;
  logic [1:0]          flagsNext;

  ecc_cap_satcnt #(.W(CNT_W)) i_sbeCnt (
    .clk(clk), .rstN(rstN), .inc(stb.incSbe), .clr(stb.clrSbeCnt), .q(sbeCnt)
  );
  ecc_cap_satcnt #(.W(CNT_W)) i_dbeCnt (
    .clk(clk), .rstN(rstN), .inc(stb.incDbe), .clr(stb.clrDbeCnt), .q(dbeCnt)
  );

  always_comb begin
    flagsNext = stb.wrFlags ? (flags & wdBits) : flags;
    flagsNext = flagsNext | {stb.setDbe, stb.setSbe};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eccEn <= 1'b0;
      thr   <= '0;
      maskQ <= '0;
      flags <= '0;
    end else begin
      if (stb.wrCfg)  eccEn <= wdEn;
      if (stb.wrCtrl) thr   <= wdThr;
      if (stb.wrMask) maskQ <= wdBits;
      flags <= flagsNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capType <= 1'b0;
      capCs   <= '0;
      capBank <= '0;
      capRow  <= '0;
      capCol  <= '0;
      capData <= '0;
      capRecv <= '0;
      capCalc <= '0;
    end else if (stb.capture) begin
      capType <= stb.capDbe;
      capCs   <= errCs;
      capBank <= errBank;
      capRow  <= errRow;
      capCol  <= errCol;
      capData <= errData;
      capRecv <= eccRecv;
      capCalc <= eccCalc;
    end
  end

  assign irq = |(flags & maskQ);

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFS_CFG:   regRdata[EN_BIT] = eccEn;
      OFS_CTRL:  regRdata[THR_LSB +: THR_W] = thr;
      OFS_FLAGS: regRdata[1:0] = flags;
      OFS_MASK:  regRdata[1:0] = maskQ;
      OFS_SBEC:  regRdata = REG_W'(sbeCnt);
      OFS_DBEC:  regRdata = REG_W'(dbeCnt);
      OFS_LOC:   regRdata = {6'b0, capBank, capCol, 5'b0, capCs, capType};
      OFS_CALC:  regRdata = {8'b0, capRow, capCalc};
      OFS_RECV:  regRdata[CHK_W-1:0] = capRecv;
      OFS_DHI:   regRdata = capData[DATA_W-1:REG_W];
      OFS_DLO:   regRdata = capData[REG_W-1:0];
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 errSbe,
  input  logic                 errDbe,
  input  logic [CS_W-1:0]      errCs,
  input  logic [BANK_W-1:0]    errBank,
  input  logic [ROW_W-1:0]     errRow,
  input  logic [COL_W-1:0]     errCol,
  input  logic [DATA_W-1:0]    errData,
  input  logic [CHK_W-1:0]     eccRecv,
  input  logic [CHK_W-1:0]     eccCalc,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  output logic                 irq
);
  strobe_t          stb;
  logic             eccEn;
  logic [THR_W-1:0] thr;
  logic [CNT_W-1:0] sbeCnt;
  logic [CNT_W-1:0] dbeCnt;
  logic [1:0]       flags;
  logic             capType;

  ecc_cap_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .eccEn(eccEn), .thr(thr), .sbeCnt(sbeCnt),
    .errSbe(errSbe), .errDbe(errDbe),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .stb(stb)
  );

  ecc_cap_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .errCs(errCs), .errBank(errBank), .errRow(errRow), .errCol(errCol),
    .errData(errData), .eccRecv(eccRecv), .eccCalc(eccCalc),
    .wdEn(regWdata[EN_BIT]), .wdThr(regWdata[THR_LSB +: THR_W]),
    .wdBits(regWdata[1:0]), .regAddr(regAddr),
    .regRdata(regRdata), .irq(irq),
    .eccEn(eccEn), .thr(thr), .sbeCnt(sbeCnt), .dbeCnt(dbeCnt),
    .flags(flags), .capType(capType)
  );
endmodule

// File: rtl/ecc_cap_chk.sv
module ecc_cap_chk
  import ecc_cap_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              errSbe,
  input logic              errDbe,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic              eccEn,
  input logic [CNT_W-1:0]  sbeCnt,
  input logic [CNT_W-1:0]  dbeCnt,
  input logic [1:0]        flags,
  input logic              capType
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!eccEn && !regWr) |=> ($stable(sbeCnt) && $stable(dbeCnt) && $stable(flags))); // R2

  AST_SBE_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regAddr == OFS_SBEC) |=> (sbeCnt >= $past(sbeCnt))); // R3

  AST_DBE_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regAddr == OFS_DBEC) |=> (dbeCnt >= $past(dbeCnt))); // R3

  AST_SBE_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    (sbeCnt == CNT_MAX && !(regWr && regAddr == OFS_SBEC)) |=> (sbeCnt == CNT_MAX)); // R5

  AST_DBE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (eccEn && errDbe) |=> flags[1]); // R7

  AST_PAIR_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    (eccEn && errDbe && errSbe) |=> capType); // R12
endmodule

bind ecc_err_capture ecc_cap_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .errSbe(errSbe), .errDbe(errDbe),
  .regWr(regWr), .regAddr(regAddr), .eccEn(eccEn),
  .sbeCnt(sbeCnt), .dbeCnt(dbeCnt), .flags(flags), .capType(capType)
);

// File: tb/test_ecc_err_capture.sv
module test_ecc_err_capture;
  localparam int CNT_W = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        errSbe = 1'b0, errDbe = 1'b0;
  logic [1:0]  errCs = '0;
  logic [2:0]  errBank = '0;
  logic [15:0] errRow = '0;
  logic [14:0] errCol = '0;
  logic [63:0] errData = '0;
  logic [7:0]  eccRecv = '0, eccCalc = '0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0]  addr;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t expQ[$];

  always #4 clk = ~clk;

  ecc_err_capture #(.CNT_W(CNT_W)) i_ecc_err_capture (
    .clk(clk), .rstN(rstN), .errSbe(errSbe), .errDbe(errDbe),
    .errCs(errCs), .errBank(errBank), .errRow(errRow), .errCol(errCol),
    .errData(errData), .eccRecv(eccRecv), .eccCalc(eccCalc),
    .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .irq(irq)
  );

  // monitor: compares one queued read per cycle, after the driver settles
  always @(negedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      total++;
      if (regRdata !== it.exp) begin
        bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.req, it.addr, regRdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    item_t it;
    @(negedge clk);
    regAddr = a;
    it.addr = a; it.exp = e; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string req);
    @(negedge clk);
    #2;
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, e);
    end
  endtask

  task automatic setFields(input logic [1:0] cs, input logic [2:0] bank,
                           input logic [15:0] row, input logic [14:0] col,
                           input logic [63:0] data, input logic [7:0] rv,
                           input logic [7:0] cv);
    errCs = cs; errBank = bank; errRow = row; errCol = col;
    errData = data; eccRecv = rv; eccCalc = cv;
  endtask

  task automatic pulse(input logic s, input logic d, input int n);
    @(negedge clk);
    errSbe = s; errDbe = d;
    repeat (n) @(negedge clk);
    errSbe = 1'b0; errDbe = 1'b0;
  endtask

  function automatic logic [31:0] locOf(input logic [2:0] b, input logic [14:0] c,
                                        input logic [1:0] s, input logic t);
    return (32'(b) << 23) | (32'(c) << 8) | (32'(s) << 1) | 32'(t);
  endfunction

  initial begin
    #(8 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h10, 0, "R1 sbe count"); rd(8'h14, 0, "R1 dbe count");
    rd(8'h08, 0, "R1 flags");     rd(8'h18, 0, "R1 location");
    rd(8'h00, 0, "R1 config");
    chkIrq(1'b0, "R1 irq");

    // R2 disabled: nothing moves
    setFields(2'd1, 3'd2, 16'h1234, 15'h0abc, 64'hDEADBEEF_01234567, 8'h5A, 8'h5B);
    pulse(1, 1, 1);
    rd(8'h10, 0, "R2 sbe while off"); rd(8'h14, 0, "R2 dbe while off");
    rd(8'h08, 0, "R2 flags while off");

    wr(8'h00, 32'h0004_0000);
    rd(8'h00, 32'h0004_0000, "R2 enable readback");

    // R6 threshold zero: counted, not captured
    pulse(1, 0, 1);
    rd(8'h10, 1, "R3 sbe count one");
    rd(8'h08, 0, "R6 no flag at zero threshold");
    rd(8'h18, 0, "R6 no capture at zero threshold");

    // R6 threshold three
    wr(8'h04, 32'h0003_0000);
    pulse(1, 0, 1);
    rd(8'h10, 2, "R3 sbe count two");
    rd(8'h18, 0, "R6 below threshold");
    setFields(2'd3, 3'd5, 16'hBEEF, 15'h7FFF, 64'h11112222_33334444, 8'h0F, 8'hF0);
    pulse(1, 0, 1);
    rd(8'h10, 3, "R3 sbe count three");
    rd(8'h08, 1, "R6 flag at threshold");
    rd(8'h18, locOf(3'd5, 15'h7FFF, 2'd3, 1'b0), "R8 sbe location");
    rd(8'h1C, 32'h00BE_EFF0, "R9 row and calc");
    rd(8'h20, 32'h0000_000F, "R9 recv");
    rd(8'h24, 32'h1111_2222, "R9 data high");
    rd(8'h28, 32'h3333_4444, "R9 data low");
    chkIrq(1'b0, "R11 masked off");

    // R7 double-bit overwrites
    setFields(2'd2, 3'd7, 16'h0001, 15'h0010, 64'hAAAA5555_0000FFFF, 8'h81, 8'h18);
    pulse(0, 1, 1);
    rd(8'h14, 1, "R3 dbe count one");
    rd(8'h10, 3, "R3 sbe unchanged by dbe");
    rd(8'h08, 3, "R7 dbe flag");
    rd(8'h18, locOf(3'd7, 15'h0010, 2'd2, 1'b1), "R7 dbe location");
    rd(8'h1C, 32'h0000_0118, "R9 dbe row and calc");
    rd(8'h28, 32'h0000_FFFF, "R7 dbe data low");

    // R10 / R11 flags and mask
    wr(8'h0C, 32'h2);
    chkIrq(1'b1, "R11 dbe unmasked");
    wr(8'h08, 32'h1);
    rd(8'h08, 1, "R10 clear dbe only");
    chkIrq(1'b0, "R11 sbe masked");
    wr(8'h0C, 32'h1);
    chkIrq(1'b1, "R11 sbe unmasked");
    wr(8'h08, 32'h3);
    rd(8'h08, 1, "R10 ones keep flags");
    wr(8'h08, 32'h0);
    rd(8'h08, 0, "R10 zeros clear");
    chkIrq(1'b0, "R11 no flags");
    rd(8'h0C, 1, "R11 mask readback");

    // R12 simultaneous pair
    wr(8'h04, 32'h0001_0000);
    setFields(2'd1, 3'd2, 16'h1234, 15'h0abc, 64'hDEADBEEF_01234567, 8'h5A, 8'h5B);
    pulse(1, 1, 1);
    rd(8'h10, 4, "R3 pair sbe");
    rd(8'h14, 2, "R3 pair dbe");
    rd(8'h18, locOf(3'd2, 15'h0abc, 2'd1, 1'b1), "R12 pair location");
    rd(8'h08, 3, "R12 pair flags");

    // R4 counter clear
    wr(8'h10, 32'd5);
    rd(8'h10, 4, "R4 nonzero write ignored");
    wr(8'h10, 32'd0);
    rd(8'h10, 0, "R4 zero clears sbe");
    wr(8'h14, 32'd0);
    rd(8'h14, 0, "R4 zero clears dbe");

    // R2 disable again, capture kept
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0);
    setFields(2'd0, 3'd1, 16'h9999, 15'h0001, 64'h0, 8'h00, 8'h01);
    pulse(1, 1, 2);
    rd(8'h10, 0, "R2 off sbe"); rd(8'h08, 0, "R2 off flags");
    rd(8'h18, locOf(3'd2, 15'h0abc, 2'd1, 1'b1), "R2 off capture kept");

    // R5 saturation
    wr(8'h00, 32'h0004_0000);
    pulse(1, 0, 260);
    rd(8'h10, 32'd255, "R5 saturate");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule